// File: doc/BRIEF.md
# Interrupt Status/Mask Unit with Down-Counting Timer

This block collects event strobes from neighbouring engines into a 16-bit status word, gates that word with a 16-bit enable mask and drives one level-sensitive interrupt line. Software reaches both words through a small 16-bit register port. A status bit is acknowledged by writing a 1 to it.

The block also holds a 32-bit general-purpose timer. The timer is seen on the port as a low half and a high half. It counts down once for each tick-enable pulse, which the system derives from a 5 MHz reference inside the same clock domain. Start and stop strobes control the timer. When the timer passes below zero it reloads to all ones, keeps counting and raises the timer status bit. Acknowledging the resources-exhausted bit sends a one-cycle request to the receive engine, which then fetches its next buffer resource.

Top module: `irq_timer_top`

## Requirements
- R1: `irq` is registered. It equals the OR of (mask AND status) and follows any change of either word in the same cycle in which the word changes.
- R2: A write to status (address 0) clears each bit that is written as 1 and is currently set. Bits written as 0 keep their value.
- R3: Mask (address 1) takes bits 14..0 from a write. Bit 15 is always stored and read as 0.
- R4: Event strobe lines 4, 5, 6, 9, 10, 11 and 12 set the status bit of the same number at the next edge. The other strobe lines have no effect. Status bit 7 is set only by the timer, so status never holds a value outside 0x1EF0.
- R5: If an event strobe and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R6: When a write actually clears status bit 5, `rsrc_req` is high for exactly the one cycle after that write. A write of 1 to a bit 5 that is already clear, or a clear that loses to a set, gives no pulse.
- R7: The count is high half (address 3) : low half (address 2). While running, the count falls by one per `tick_en` cycle, with the borrow carried from the low half into the high half. The count never changes in a cycle without `tick_en`.
- R8: A running tick at count 0 loads 0xFFFF_FFFF, sets status bit 7, and counting goes on.
- R9: `tmr_stop` halts counting and freezes the readable count. `tmr_start` resumes counting. Stop wins if both arrive together.
- R10: A write to either timer half is held as pending and loaded into the count at the next `tick_en`, whether the timer runs or not. Until then the old count is read back. The half that was not written is taken from the pending value or, if nothing is pending, from the current count.
- R11: After reset, status, mask and count are 0, the timer is stopped, and `irq` and `rsrc_req` are low.
- R12: A read returns the register selected by `bus_addr` on `bus_rdata` in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 status, 1 mask, 2 timer low, 3 timer high |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| evt_set | input | DW | Event strobes, one line per status bit |
| tmr_start | input | 1 | Timer start strobe |
| tmr_stop | input | 1 | Timer stop strobe |
| tick_en | input | 1 | Count-enable pulse at the timer rate |
| irq | output | 1 | Level interrupt |
| rsrc_req | output | 1 | One-cycle request to fetch the next receive resource |

## Verification
The bench builds the block with its default width of 16, so the timer is 32 bits wide. This width puts the borrow from the low half into the high half within reach of a few ticks. Underflow is reached by loading the count to 1 through the pending path rather than by waiting out the full range. The same-cycle collisions between a set and a clear, on bit 6 and on bit 5, are driven directly so that the rule that a set wins can be seen both in the status word and in the absence of the fetch pulse.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_TLOW   = 2'd2,
    SEL_THIGH  = 2'd3
  } reg_sel_e;

  // status bit positions (other engines decode these)
  localparam int BIT_BUF_OVER  = 4;
  localparam int BIT_RSRC_OUT  = 5;
  localparam int BIT_DESC_OUT  = 6;
  localparam int BIT_TMR_DONE  = 7;
  localparam int BIT_TX_DONE   = 9;
  localparam int BIT_RX_PKT    = 10;
  localparam int BIT_PROG_IRQ  = 11;
  localparam int BIT_ADDR_LOAD = 12;

  function automatic logic [15:0] evt_line_mask();
    logic [15:0] m;
    m = '0;
    m[BIT_BUF_OVER]  = 1'b1;
    m[BIT_RSRC_OUT]  = 1'b1;
    m[BIT_DESC_OUT]  = 1'b1;
    m[BIT_TX_DONE]   = 1'b1;
    m[BIT_RX_PKT]    = 1'b1;
    m[BIT_PROG_IRQ]  = 1'b1;
    m[BIT_ADDR_LOAD] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int DW       = 16,
  parameter int RSRC_BIT = 5,
  parameter int TMR_BIT  = 7,
  parameter logic [DW-1:0] EVT_MASK = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_wr,
  input  logic [DW-1:0] clr_data,
  input  logic [DW-1:0] evt_set,
  input  logic          tmr_set,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] stat_nxt,
  output logic          fetch_req
);

  logic [DW-1:0] set_v;
  logic [DW-1:0] clr_v;
  logic          fetch_nxt;

  always_comb begin
    set_v          = evt_set & EVT_MASK;
    set_v[TMR_BIT] = tmr_set;
    clr_v          = clr_wr ? (clr_data & stat_q) : '0;
    stat_nxt       = (stat_q & ~clr_v) | set_v;
    fetch_nxt      = clr_v[RSRC_BIT] & ~set_v[RSRC_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= '0;
      fetch_req <= 1'b0;
    end else begin
      stat_q    <= stat_nxt;
      fetch_req <= fetch_nxt;
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_wr,
  input  logic [DW-1:0] mask_wdata,
  input  logic [DW-1:0] stat_nxt,
  output logic [DW-1:0] mask_q,
  output logic          irq_q
);

  logic [DW-1:0] mask_nxt;

  always_comb begin
    mask_nxt = mask_q;
    if (mask_wr) mask_nxt = {1'b0, mask_wdata[DW-2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      irq_q  <= |(mask_nxt & stat_nxt);
    end
  end

endmodule

// File: rtl/wd_down_timer.sv
module wd_down_timer #(
  parameter int HW = 16,
  localparam int CW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          tick,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wdata,
  output logic [CW-1:0] count_q,
  output logic          run_q,
  output logic          pend_q,
  output logic          underflow
);

  logic [CW-1:0] pend_val;
  logic [CW-1:0] merged;

  always_comb begin
    merged = pend_q ? pend_val : count_q;
    if (wr_lo) merged[HW-1:0]  = wdata;
    if (wr_hi) merged[CW-1:HW] = wdata;
    underflow = tick & run_q & ~pend_q & (count_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
      pend_val <= '0;
    end else begin
      if (tick && pend_q)      count_q <= pend_val;
      else if (underflow)      count_q <= '1;
      else if (tick && run_q)  count_q <= count_q - 1'b1;

      if (wr_lo || wr_hi) begin
        pend_val <= merged;
        pend_q   <= 1'b1;
      end else if (tick) begin
        pend_q   <= 1'b0;
      end

      if (stop)       run_q <= 1'b0;
      else if (start) run_q <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_timer_top.sv
module irq_timer_top
  import irq_timer_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] evt_set,
  input  logic          tmr_start,
  input  logic          tmr_stop,
  input  logic          tick_en,
  output logic          irq,
  output logic          rsrc_req
);

  localparam int CW = 2 * DW;
  localparam logic [DW-1:0] EVT_LINES = DW'(evt_line_mask());

  reg_sel_e      sel;
  logic          wr_stat, wr_mask, wr_lo, wr_hi;
  logic [DW-1:0] stat_q, stat_nxt, mask_q;
  logic [CW-1:0] count_q;
  logic          run_q, pend_q, tmr_uf;

  always_comb begin
    sel     = reg_sel_e'(bus_addr);
    wr_stat = bus_wr && (sel == SEL_STATUS);
    wr_mask = bus_wr && (sel == SEL_MASK);
    wr_lo   = bus_wr && (sel == SEL_TLOW);
    wr_hi   = bus_wr && (sel == SEL_THIGH);
  end

  irq_status_reg #(
    .DW(DW), .RSRC_BIT(BIT_RSRC_OUT), .TMR_BIT(BIT_TMR_DONE), .EVT_MASK(EVT_LINES)
  ) u_stat (
    .clk(clk), .rst(rst), .clr_wr(wr_stat), .clr_data(bus_wdata),
    .evt_set(evt_set), .tmr_set(tmr_uf), .stat_q(stat_q),
    .stat_nxt(stat_nxt), .fetch_req(rsrc_req)
  );

  irq_mask_reg #(.DW(DW)) u_mask (
    .clk(clk), .rst(rst), .mask_wr(wr_mask), .mask_wdata(bus_wdata),
    .stat_nxt(stat_nxt), .mask_q(mask_q), .irq_q(irq)
  );

  wd_down_timer #(.HW(DW)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .stop(tmr_stop), .tick(tick_en),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata), .count_q(count_q),
    .run_q(run_q), .pend_q(pend_q), .underflow(tmr_uf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (sel)
        SEL_STATUS: bus_rdata <= stat_q;
        SEL_MASK:   bus_rdata <= mask_q;
        SEL_TLOW:   bus_rdata <= count_q[DW-1:0];
        SEL_THIGH:  bus_rdata <= count_q[CW-1:DW];
        default:    bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk
  import irq_timer_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          rsrc_req,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] evt_set,
  input logic [2*DW-1:0] count_q,
  input logic          run_q,
  input logic          pend_q,
  input logic          tick_en
);

  localparam logic [DW-1:0] LEGAL = DW'(evt_line_mask()) | (DW'(1) << BIT_TMR_DONE);

  // R1
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(mask_q & stat_q));

  // R3
  mask_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_q[DW-1]);

  // R4
  stat_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~LEGAL) == '0);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    evt_set[BIT_DESC_OUT] |=> stat_q[BIT_DESC_OUT]);

  // R6
  fetch_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsrc_req |=> !rsrc_req);

  // R6
  fetch_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    rsrc_req |-> !stat_q[BIT_RSRC_OUT]);

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(count_q));

  // R8
  underflow_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && run_q && !pend_q && count_q == '0) |=> (count_q == '1 && stat_q[BIT_TMR_DONE]));

endmodule

bind irq_timer_top irq_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .rsrc_req(rsrc_req), .stat_q(stat_q),
  .mask_q(mask_q), .evt_set(evt_set), .count_q(count_q), .run_q(run_q),
  .pend_q(pend_q), .tick_en(tick_en)
);

// File: tb/tb_irq_timer_top.sv
module tb_irq_timer_top;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] evt_set = '0;
  logic          tmr_start = 1'b0, tmr_stop = 1'b0, tick_en = 1'b0;
  logic          irq, rsrc_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_timer_top #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .tmr_start(tmr_start), .tmr_stop(tmr_stop), .tick_en(tick_en),
    .irq(irq), .rsrc_req(rsrc_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [DW-1:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic cmd(input logic go, input logic halt);
    @(negedge clk);
    tmr_start = go; tmr_stop = halt;
    @(negedge clk);
    tmr_start = 1'b0; tmr_stop = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R11 irq", irq, 0);
    check("R11 rsrc_req", rsrc_req, 0);
    rd(2'd0, d); check("R11/R12 status", d, 0);
    rd(2'd1, d); check("R11 mask", d, 0);
    rd(2'd2, d); check("R11 tlow", d, 0);
    ticks(2);
    rd(2'd2, d); check("R11 timer stopped", d, 0);
  endtask

  task automatic t_events();
    logic [DW-1:0] d;
    pulse_evt(16'hFFFF);
    check("R1 irq masked off", irq, 0);
    rd(2'd0, d); check("R4 status after all lines", d, 16'h1E70);
  endtask

  task automatic t_w1c();
    logic [DW-1:0] d;
    wr(2'd0, 16'h0210);
    check("R6 no pulse for other bits", rsrc_req, 0);
    rd(2'd0, d); check("R2 clear 4 and 9", d, 16'h1C60);
    wr(2'd0, 16'h0180);
    rd(2'd0, d); check("R2 clear of unset bits", d, 16'h1C60);
  endtask

  task automatic t_mask();
    logic [DW-1:0] d;
    wr(2'd1, 16'hFFFF);
    check("R1 irq on mask", irq, 1);
    rd(2'd1, d); check("R3 mask msb", d, 16'h7FFF);
    wr(2'd1, 16'h0100);
    check("R1 irq off", irq, 0);
    wr(2'd1, 16'h0040);
    check("R1 irq bit6", irq, 1);
  endtask

  task automatic t_fetch();
    logic [DW-1:0] d;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0020;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R6 pulse", rsrc_req, 1);
    @(negedge clk);
    check("R6 pulse width", rsrc_req, 0);
    rd(2'd0, d); check("R6 bit5 cleared", d, 16'h1C40);
    wr(2'd0, 16'h0020);
    check("R6 no pulse when clear", rsrc_req, 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    @(negedge clk);
    evt_set = 16'h0040; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0040;
    @(negedge clk);
    evt_set = '0; bus_wr = 1'b0;
    rd(2'd0, d); check("R5 bit6 stays", d, 16'h1C40);
    check("R1 irq stays", irq, 1);
    pulse_evt(16'h0020);
    @(negedge clk);
    evt_set = 16'h0020; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0020;
    @(negedge clk);
    evt_set = '0; bus_wr = 1'b0;
    check("R5/R6 no pulse on lost clear", rsrc_req, 0);
    wr(2'd0, 16'hFFFF);
    check("R6 pulse on full clear", rsrc_req, 1);
    check("R1 irq after clear", irq, 0);
    rd(2'd0, d); check("R2 all cleared", d, 0);
  endtask

  task automatic t_timer();
    logic [DW-1:0] d;
    wr(2'd2, 16'h0003);
    wr(2'd3, 16'h0001);
    rd(2'd2, d); check("R10 old count before tick", d, 0);
    ticks(1);
    rd(2'd2, d); check("R10 low loaded", d, 16'h0003);
    rd(2'd3, d); check("R10 high loaded", d, 16'h0001);
    ticks(2);
    rd(2'd2, d); check("R9 stopped holds", d, 16'h0003);
    cmd(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    rd(2'd2, d); check("R7 no tick no count", d, 16'h0003);
    ticks(4);
    rd(2'd2, d); check("R7 borrow low", d, 16'hFFFF);
    rd(2'd3, d); check("R7 borrow high", d, 16'h0000);
  endtask

  task automatic t_underflow();
    logic [DW-1:0] d;
    wr(2'd2, 16'h0001);
    ticks(2);
    rd(2'd0, d); check("R8 no flag yet", d, 0);
    rd(2'd2, d); check("R7 at zero", d, 0);
    ticks(1);
    rd(2'd2, d); check("R8 reload low", d, 16'hFFFF);
    rd(2'd3, d); check("R8 reload high", d, 16'hFFFF);
    rd(2'd0, d); check("R8 flag", d, 16'h0080);
    wr(2'd1, 16'h0080);
    check("R1 timer irq", irq, 1);
    ticks(1);
    rd(2'd2, d); check("R8 keeps counting", d, 16'hFFFE);
  endtask

  task automatic t_stopstart();
    logic [DW-1:0] d;
    cmd(1'b1, 1'b1);
    ticks(2);
    rd(2'd2, d); check("R9 stop wins", d, 16'hFFFE);
    cmd(1'b1, 1'b0);
    ticks(1);
    rd(2'd2, d); check("R9 resumed", d, 16'hFFFD);
    rd(2'd3, d); check("R9 high", d, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_events();
    t_w1c();
    t_mask();
    t_fetch();
    t_collide();
    t_timer();
    t_underflow();
    t_stopstart();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule